// File: doc/BRIEF.md
# Bang-Bang Split-Path Loop Filter

This block is the digital loop filter of a bang-bang clock and data recovery loop. Each bit period it receives one ternary phase-detector decision: clock late, clock early, or no data transition. The block steers the oscillator through two separate outputs. The first is a proportional output, which repeats each decision in the same cycle it arrives. The second is an integral output, which follows a slow, decimated integrator.

The integral path works at one quarter of the bit rate. Four consecutive decisions are collected and reduced to one vote by majority. The vote moves a saturating 14-bit accumulator up or down by one step. The upper 11 bits of the accumulator feed a second-order error-feedback delta-sigma modulator, and the modulator emits a three-level code for the integral DAC. The loop is meant to be heavily over-damped: the DAC scaling makes one proportional step move phase more than a thousand times further than one integral step. That ratio comes from the analog side, and this logic does not set it.

Top module: `bbcdr_loop_filter`

## Requirements
- R1: Ternary codes are two-bit signed values: 2'b01 means +1 (late), 2'b11 means -1 (early), 2'b00 means 0 (no transition). The unused code 2'b10 on the input is taken as 0 on both paths.
- R2: `prop_code` shows the cleaned `pd_code` value combinationally, in the same cycle, with no register and no accumulation.
- R3: After reset is released, inputs are grouped in fours starting with the first sampled cycle. The vote of a group is the sign of the sum of its four values, and a sum of zero gives a vote of 0.
- R4: The accumulator is 14 bits wide. It changes only in the cycle after a group completes, and then it adds the vote (+1, 0 or -1).
- R5: The accumulator saturates. It stays at 16383 on a +1 vote and stays at 0 on a -1 vote; it does not wrap.
- R6: The modulator steps one cycle after each accumulator update and holds `int_code` between steps. At each step it computes u = (acc >> 3) - 1024 and v = u - 2*e1 + e2, where e1 is the newest stored error and e2 is the one before it. The output y is +1 if v >= 512, -1 if v < -512, and 0 otherwise. The new error is 1024*y - v, clamped to [-512, 511].
- R7: `int_code` uses the encoding of R1 and never shows 2'b10.
- R8: Synchronous reset (active high) sets the accumulator to mid-scale 8192 and clears both modulator errors, the group state and `int_code` (to 2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_code | input | 2 | Phase-detector decision for this bit |
| prop_code | output | 2 | Proportional DAC control, same cycle as the input |
| int_code | output | 2 | Integral DAC control from the modulator |

## Verification
Every internal state is seen only through `int_code`, so the bench follows the whole chain with its own model and compares the output every cycle. A wrong vote or a wrong grouping shifts the accumulator, and the modulator shows this two cycles after the group ends whenever the change reaches the upper 11 bits; otherwise it shows within the next eight updates. A wrong modulator error term alters the pattern of `int_code` at the next step. A saturation fault becomes a sudden flip of the integral code from a run of +1 to a run of -1 (or the reverse) once the rail is pushed. A fault in the proportional path appears in the same cycle.

// File: rtl/bbdlf_pkg.sv
package bbdlf_pkg;

  typedef logic [1:0] tern_t;

  localparam tern_t TERN_ZERO = 2'b00;
  localparam tern_t TERN_POS  = 2'b01;
  localparam tern_t TERN_NEG  = 2'b11;

  // Signed value of a code; the unused code counts as zero.
  function automatic int tern_val(tern_t c);
    case (c)
      TERN_POS: return 1;
      TERN_NEG: return -1;
      default:  return 0;
    endcase
  endfunction

  function automatic tern_t int_to_tern(int v);
    if (v > 0)      return TERN_POS;
    else if (v < 0) return TERN_NEG;
    else            return TERN_ZERO;
  endfunction

  function automatic tern_t tern_clean(tern_t c);
    return int_to_tern(tern_val(c));
  endfunction

  // Three-level quantizer of the modulator.
  function automatic tern_t dsm_level(int v, int half);
    if (v >= half)      return TERN_POS;
    else if (v < -half) return TERN_NEG;
    else                return TERN_ZERO;
  endfunction

  // Quantization error, clamped to the half-step range.
  function automatic int dsm_error(int v, tern_t y, int fs, int half);
    int e;
    e = tern_val(y) * fs - v;
    if (e > half - 1) e = half - 1;
    if (e < -half)    e = -half;
    return e;
  endfunction

endpackage

// File: rtl/bbdlf_decimator.sv
module bbdlf_decimator
  import bbdlf_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  tern_t pd,
  output tern_t vote,
  output logic  vote_vld
);
  localparam int CNT_W = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int SUM_W = $clog2(GROUP + 1) + 1;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_next;
  logic                    group_last;
  tern_t                   vote_q;
  logic                    vld_q;

  assign group_last = (cnt_q == CNT_W'(GROUP - 1));

  always_comb begin
    sum_next = sum_q + SUM_W'(tern_val(pd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      vote_q <= TERN_ZERO;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= group_last;
      if (group_last) begin
        cnt_q  <= '0;
        sum_q  <= '0;
        vote_q <= int_to_tern(int'(sum_next));
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        sum_q <= sum_next;
      end
    end
  end

  assign vote     = vote_q;
  assign vote_vld = vld_q;

  // R3: one vote per group, never two in a row
  assert_vote_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    vote_vld |=> !vote_vld);

  // R3: a vote only follows the last member of a group
  assert_vote_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    group_last |=> vote_vld);

endmodule

// File: rtl/bbdlf_integrator.sv
module bbdlf_integrator
  import bbdlf_pkg::*;
#(
  parameter int ACC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  tern_t            step,
  input  logic             step_vld,
  output logic [ACC_W-1:0] acc,
  output logic             acc_vld
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] ACC_MID = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q;
  logic             vld_q;
  logic             at_max;
  logic             at_min;
  logic             rail_hit;

  assign at_max   = (acc_q == ACC_MAX);
  assign at_min   = (acc_q == '0);
  assign rail_hit = step_vld && ((at_max && step == TERN_POS) ||
                                 (at_min && step == TERN_NEG));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= ACC_MID;
      vld_q <= 1'b0;
    end else begin
      vld_q <= step_vld;
      if (step_vld && !rail_hit) begin
        case (step)
          TERN_POS: acc_q <= acc_q + ACC_W'(1);
          TERN_NEG: acc_q <= acc_q - ACC_W'(1);
          default:  acc_q <= acc_q;
        endcase
      end
    end
  end

  assign acc     = acc_q;
  assign acc_vld = vld_q;

  // R4: no vote, no change
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step_vld |=> $stable(acc));

  // R5: upper rail holds
  assert_ceiling_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (step_vld && step == TERN_POS && acc == ACC_MAX) |=> acc == ACC_MAX);

  // R5: lower rail holds
  assert_floor_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (step_vld && step == TERN_NEG && acc == '0) |=> acc == '0);

endmodule

// File: rtl/bbdlf_dsm2.sv
module bbdlf_dsm2
  import bbdlf_pkg::*;
#(
  parameter int IN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] code,
  input  logic            code_vld,
  output tern_t           level
);
  localparam int FS   = 1 << (IN_W - 1);
  localparam int HALF = FS / 2;
  localparam int W    = IN_W + 3;

  logic signed [W-1:0] e1_q;
  logic signed [W-1:0] e2_q;
  tern_t               level_q;
  int                  u_i;
  int                  v_i;
  int                  err_i;
  tern_t               y_t;

  always_comb begin
    u_i   = int'(code) - FS;
    v_i   = u_i - 2 * int'(e1_q) + int'(e2_q);
    y_t   = dsm_level(v_i, HALF);
    err_i = dsm_error(v_i, y_t, FS, HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e1_q    <= '0;
      e2_q    <= '0;
      level_q <= TERN_ZERO;
    end else if (code_vld) begin
      e1_q    <= W'(err_i);
      e2_q    <= e1_q;
      level_q <= y_t;
    end
  end

  assign level = level_q;

  // R6: output only moves on a modulator step
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !code_vld |=> $stable(level));

  // R6: the older error is the previous newest error after a step
  assert_error_shift_R6: assert property (@(posedge clk) disable iff (rst)
    code_vld |=> e2_q == $past(e1_q));

endmodule

// File: rtl/bbcdr_loop_filter.sv
module bbcdr_loop_filter
  import bbdlf_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int ACC_W = 14,
  parameter int DSM_W = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pd_code,
  output logic [1:0] prop_code,
  output logic [1:0] int_code
);
  tern_t            vote;
  logic             vote_vld;
  logic [ACC_W-1:0] acc;
  logic             acc_vld;
  logic [DSM_W-1:0] acc_msb;

  // Proportional path: straight through, only the unused code is cleaned
  assign prop_code = tern_clean(pd_code);

  bbdlf_decimator #(.GROUP(GROUP)) u_decim (
    .clk      (clk),
    .rst      (rst),
    .pd       (pd_code),
    .vote     (vote),
    .vote_vld (vote_vld)
  );

  bbdlf_integrator #(.ACC_W(ACC_W)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .step     (vote),
    .step_vld (vote_vld),
    .acc      (acc),
    .acc_vld  (acc_vld)
  );

  assign acc_msb = acc[ACC_W-1 -: DSM_W];

  bbdlf_dsm2 #(.IN_W(DSM_W)) u_dsm (
    .clk      (clk),
    .rst      (rst),
    .code     (acc_msb),
    .code_vld (acc_vld),
    .level    (int_code)
  );

  // R2: no transition in, no proportional step out
  assert_prop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (pd_code == TERN_ZERO) |-> (prop_code == TERN_ZERO));

  // R7: the integral output never carries the unused code
  assert_int_legal_R7: assert property (@(posedge clk) disable iff (rst)
    int_code != 2'b10);

endmodule

// File: tb/test_bbcdr_loop_filter.sv
module test_bbcdr_loop_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pd_code = 2'b00;
  logic [1:0] prop_code;
  logic [1:0] int_code;

  int checks = 0;
  int failures = 0;
  bit chk_on = 0;
  bit done = 0;
  string phase = "R8 reset";

  always #4 clk = ~clk;

  bbcdr_loop_filter i_bbcdr_loop_filter (
    .clk(clk), .rst(rst), .pd_code(pd_code),
    .prop_code(prop_code), .int_code(int_code)
  );

  function automatic int b_val(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] b_code(int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b11;
    return 2'b00;
  endfunction

  // Behavioural reference, written from the requirements
  int m_cnt, m_sum, m_vote, m_acc, m_e1, m_e2, m_int;
  int o_vote, u, v, y, e, s;
  bit m_vld, m_accv, o_vld, o_accv;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_sum = 0; m_vote = 0; m_vld = 0;
      m_acc = 8192; m_accv = 0; m_e1 = 0; m_e2 = 0; m_int = 0;
    end else begin
      o_vld = m_vld; o_accv = m_accv; o_vote = m_vote;
      if (o_accv) begin
        u = (m_acc / 8) - 1024;
        v = u - 2 * m_e1 + m_e2;
        y = (v >= 512) ? 1 : ((v < -512) ? -1 : 0);
        e = 1024 * y - v;
        if (e > 511) e = 511;
        if (e < -512) e = -512;
        m_e2 = m_e1; m_e1 = e; m_int = y;
      end
      m_accv = o_vld;
      if (o_vld) begin
        m_acc = m_acc + o_vote;
        if (m_acc > 16383) m_acc = 16383;
        if (m_acc < 0) m_acc = 0;
      end
      s = m_sum + b_val(pd_code);
      if (m_cnt == 3) begin
        m_vote = (s > 0) ? 1 : ((s < 0) ? -1 : 0);
        m_vld = 1; m_sum = 0; m_cnt = 0;
      end else begin
        m_vld = 0; m_sum = s; m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      if (failures < 20)
        $display("FAIL %s [%s] actual=%b expected=%b t=%0t", req, phase, act, exp, $time);
    end
  endtask

  // Compare at the falling edge, away from all sampling
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R2 prop", prop_code, b_code(b_val(pd_code)));
      check("R6 int", int_code, b_code(m_int));
      checks++;
      if (int_code == 2'b10) begin
        failures++;
        $display("FAIL R7 actual=%b expected=not 10", int_code);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic drive(logic [1:0] c, int n);
    for (int i = 0; i < n; i++) begin
      pd_code = c;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    @(posedge clk); #2;
    chk_on = 1;
    // R8: state during reset
    phase = "R8 reset";
    pd_code = 2'b01; @(posedge clk); #2;
    pd_code = 2'b11; @(posedge clk); #2;
    check("R8 int during reset", int_code, 2'b00);
    pd_code = 2'b00;
    rst = 0;
    // R1 / R3: code map, ties and the unused code
    phase = "R1 R3 directed groups";
    drive(2'b01, 1); drive(2'b11, 1); drive(2'b01, 1); drive(2'b11, 1);
    drive(2'b01, 2); drive(2'b11, 1); drive(2'b00, 1);
    drive(2'b10, 2); drive(2'b01, 1); drive(2'b00, 1);
    drive(2'b11, 3); drive(2'b01, 1);
    drive(2'b10, 4);
    drive(2'b00, 12);
    // R4: random walk around mid-scale
    phase = "R4 random walk";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[1:0], 1);
    end
    // R5: push to the upper rail and beyond
    phase = "R5 ceiling";
    drive(2'b01, 34000);
    phase = "R5 floor";
    drive(2'b11, 66000);
    phase = "R6 recovery";
    drive(2'b01, 400);
    drive(2'b00, 100);
    // R8: reset again mid-run
    phase = "R8 second reset";
    rst = 1; drive(2'b01, 3);
    check("R8 int after reset", int_code, 2'b00);
    rst = 0;
    drive(2'b11, 200);
    #1;
    finish_run();
  end
endmodule